// File: doc/BRIEF.md
# LFSR Noise Channel Generator

This block produces the noise voice of a programmable sound generator. A 15-bit shift register makes a pseudo-random bit stream in white mode. In periodic mode a single circulating one makes a narrow pulse train instead. The register steps on every second expiry of a rate timer.

The rate timer either counts reference ticks with one of three fixed reloads, or passes through the expiry pulses of tone channel 2. The block outputs the current noise bit and an amplitude sample. The sample is taken from a 2 dB-per-step attenuation scale.

A register-write decoder sits upstream. It presents the 3-bit noise control and the 4-bit attenuation as levels, and it pulses a write strobe whenever the noise control is written. The mixer downstream sums the amplitude sample with the tone voices.

Top module: `lfsr_noise_channel`

## Requirements
- R1: While `rst` is high at a rising clock edge, `noise_bit` and `amp_sample` go to 0, the shift register takes 15'h4000, the step phase clears and the rate counter clears. The first reference tick after reset is therefore an expiry.
- R2: With `noise_ctrl[1:0]` at 0, 1 or 2, an expiry occurs on the reference tick that finds the counter at 1 or below. The counter then reloads with 16, 32 or 64 respectively, taken from the rate select at that moment; otherwise each tick decrements it. A changed select only takes effect at the next reload.
- R3: With `noise_ctrl[1:0]` = 3, every `tone2_expire` pulse is an expiry and reference ticks cause none, whatever `atten` is.
- R4: Each expiry toggles a step-phase flag. The shift register advances only on expiries that find the flag at 0, so it advances on every second expiry, starting with the first after reset.
- R5: On an advance, the register shifts right by one. The bit leaving position 0 is registered as `noise_bit`, and bit 14 takes the feedback. With `noise_ctrl[2]` = 1 the feedback is bit 0 XOR bit 1, so the output repeats every 32767 advances and holds 16384 ones per repeat.
- R6: With `noise_ctrl[2]` = 0 the feedback is bit 0 itself. After a reseed, `noise_bit` is 1 on exactly one advance in every 15, starting with the 15th.
- R7: A cycle with `ctrl_wr` high reloads the shift register with 15'h4000 and suppresses any advance in that cycle. It leaves `noise_bit` unchanged, and the step phase still toggles if that cycle is an expiry.
- R8: `amp_sample` is 0 while `noise_bit` is 0. Otherwise it is round(32767 × 10^(−k/10)) for attenuation code k in 0..14, following `noise_bit` and `atten` in the same cycle.
- R9: Attenuation code 15 forces `amp_sample` to 0 whatever `noise_bit` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle reference tick for the rate counter |
| tone2_expire | input | 1 | One-cycle expiry pulse from tone channel 2 |
| ctrl_wr | input | 1 | Pulse raised on each noise-control write; reseeds the register |
| noise_ctrl | input | 3 | Bit 2 selects white (1) or periodic (0); bits 1:0 select the rate |
| atten | input | 4 | Attenuation code, 0 loudest, 15 silent |
| noise_bit | output | 1 | Last bit shifted out of the register |
| amp_sample | output | 16 | Attenuated amplitude while the noise bit is 1 |

## Verification
An expiry caused by inputs sampled at a rising edge moves `noise_bit` at that same edge, so it is due one edge after the tick or pulse is driven. `amp_sample` is combinational on `noise_bit` and `atten`, so it is due in the same cycle. The bench drives inputs one nanosecond after each falling edge. At the next falling edge, half a period after the rising edge, it compares both outputs with a behavioural model that it steps on every rising edge. The duty and period checks count output ones over windows that are whole multiples of the advance spacing, so their totals do not depend on the step phase at the start.

// File: rtl/noise_pkg.sv
package noise_pkg;
    parameter int LFSR_W      = 15;
    parameter int LEVEL_W     = 16;
    parameter int BASE_RELOAD = 16;
    localparam int RELOAD_MAX = BASE_RELOAD * 4;
    localparam int CNT_W      = $clog2(RELOAD_MAX + 1);

    typedef enum logic [1:0] {
        RATE_FAST  = 2'd0,
        RATE_MID   = 2'd1,
        RATE_SLOW  = 2'd2,
        RATE_TONE2 = 2'd3
    } rate_e;

    typedef struct packed {
        logic  white;
        rate_e rate;
    } noise_ctrl_t;

    typedef logic [LFSR_W-1:0] shreg_t;
    localparam shreg_t SEED = shreg_t'(1) << (LFSR_W - 1);

    function automatic logic [CNT_W-1:0] reload_of(rate_e r);
        logic [CNT_W-1:0] base;
        base = CNT_W'(BASE_RELOAD);
        if (r == RATE_TONE2) return base;
        return base << r;
    endfunction

    function automatic logic [LEVEL_W-1:0] level_of(logic [3:0] code);
        case (code)
            4'd0:    return 16'd32767;
            4'd1:    return 16'd26028;
            4'd2:    return 16'd20675;
            4'd3:    return 16'd16422;
            4'd4:    return 16'd13045;
            4'd5:    return 16'd10362;
            4'd6:    return 16'd8231;
            4'd7:    return 16'd6538;
            4'd8:    return 16'd5193;
            4'd9:    return 16'd4125;
            4'd10:   return 16'd3277;
            4'd11:   return 16'd2603;
            4'd12:   return 16'd2067;
            4'd13:   return 16'd1642;
            4'd14:   return 16'd1304;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/noise_rate_timer.sv
module noise_rate_timer
    import noise_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ref_tick,
    input  logic  tone2_expire,
    input  rate_e rate,
    output logic  expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (ref_tick)
            cnt_q <= at_end ? reload_of(rate) : cnt_q - CNT_W'(1);
    end

    always_comb begin
        if (rate == RATE_TONE2)
            expire = tone2_expire;
        else
            expire = ref_tick && at_end;
    end
endmodule

// File: rtl/noise_shifter.sv
module noise_shifter
    import noise_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   expire,
    input  logic   reseed,
    input  logic   white,
    output shreg_t shreg_q,
    output logic   step_phase,
    output logic   noise_bit
);
    logic feedback;
    logic advance;

    assign feedback = white ? (shreg_q[0] ^ shreg_q[1]) : shreg_q[0];
    assign advance  = expire && !step_phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q    <= SEED;
            step_phase <= 1'b0;
            noise_bit  <= 1'b0;
        end else begin
            if (expire)
                step_phase <= ~step_phase;
            if (reseed) begin
                shreg_q <= SEED;
            end else if (advance) begin
                noise_bit <= shreg_q[0];
                shreg_q   <= {feedback, shreg_q[LFSR_W-1:1]};
            end
        end
    end
endmodule

// File: rtl/noise_attenuator.sv
module noise_attenuator
    import noise_pkg::*;
(
    input  logic               noise_bit,
    input  logic [3:0]         atten,
    output logic [LEVEL_W-1:0] amp_sample
);
    localparam logic [3:0] MUTE_CODE = 4'hF;

    always_comb begin
        if (noise_bit && (atten != MUTE_CODE))
            amp_sample = level_of(atten);
        else
            amp_sample = '0;
    end
endmodule

// File: rtl/lfsr_noise_channel.sv
module lfsr_noise_channel
    import noise_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_tick,
    input  logic         tone2_expire,
    input  logic         ctrl_wr,
    input  logic [2:0]   noise_ctrl,
    input  logic [3:0]   atten,
    output logic         noise_bit,
    output logic [15:0]  amp_sample
);
    noise_ctrl_t ctl;
    logic        expire;
    logic        step_phase;
    shreg_t      shreg_q;

    assign ctl = noise_ctrl_t'(noise_ctrl);

    noise_rate_timer u_timer (
        .clk          (clk),
        .rst          (rst),
        .ref_tick     (ref_tick),
        .tone2_expire (tone2_expire),
        .rate         (ctl.rate),
        .expire       (expire)
    );

    noise_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .expire     (expire),
        .reseed     (ctrl_wr),
        .white      (ctl.white),
        .shreg_q    (shreg_q),
        .step_phase (step_phase),
        .noise_bit  (noise_bit)
    );

    noise_attenuator u_atten (
        .noise_bit  (noise_bit),
        .atten      (atten),
        .amp_sample (amp_sample)
    );
endmodule

// File: rtl/noise_channel_checker.sv
module noise_channel_checker
    import noise_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         ctrl_wr,
    input logic [3:0]   atten,
    input logic         noise_bit,
    input logic [15:0]  amp_sample,
    input logic         expire,
    input logic         step_phase,
    input shreg_t       shreg_q
);
    AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (atten == 4'hF) |-> (amp_sample == '0)); // R9

    AST_LOW_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !noise_bit |-> (amp_sample == '0)); // R8

    AST_HOLD_WITHOUT_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        !expire |=> $stable(noise_bit)); // R4

    AST_PHASE_FLIPS: assert property (@(posedge clk) disable iff (rst)
        expire |=> (step_phase != $past(step_phase))); // R4

    AST_ADVANCE_MOVES: assert property (@(posedge clk) disable iff (rst)
        (expire && !step_phase && !ctrl_wr) |=> !$stable(shreg_q)); // R5

    AST_RESEED_VALUE: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (shreg_q == SEED)); // R7

    AST_RESEED_KEEPS_BIT: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> $stable(noise_bit)); // R7
endmodule

bind lfsr_noise_channel noise_channel_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .atten      (atten),
    .noise_bit  (noise_bit),
    .amp_sample (amp_sample),
    .expire     (expire),
    .step_phase (step_phase),
    .shreg_q    (shreg_q)
);

// File: tb/test_lfsr_noise_channel.sv
`timescale 1ns/1ps
module test_lfsr_noise_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        tone2_expire = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [2:0]  noise_ctrl = 3'b100;
    logic [3:0]  atten = 4'd0;
    logic        noise_bit;
    logic [15:0] amp_sample;

    int checks = 0;
    int fails  = 0;
    int tick_div = 1;
    int t2_div   = 0;
    int gen_cnt  = 0;
    bit compare_on = 1'b0;
    string cur_req = "R1";

    int m_cnt, m_phase, m_lfsr, m_out;

    always #5 clk = ~clk;

    lfsr_noise_channel i_lfsr_noise_channel (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .tone2_expire(tone2_expire),
        .ctrl_wr(ctrl_wr), .noise_ctrl(noise_ctrl), .atten(atten),
        .noise_bit(noise_bit), .amp_sample(amp_sample)
    );

    function automatic int level(int k);
        if (k >= 15) return 0;
        return $rtoi(32767.0 * (10.0 ** (-0.1 * k)) + 0.5);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural model, stepped on every rising edge
    always @(posedge clk) begin
        int sel, rl, fb;
        bit ex;
        if (rst) begin
            m_cnt = 0; m_phase = 0; m_lfsr = 16384; m_out = 0;
        end else begin
            sel = noise_ctrl[1:0];
            rl  = (sel == 3) ? 16 : (16 << sel);
            ex  = (sel == 3) ? tone2_expire : (ref_tick && m_cnt <= 1);
            if (ref_tick) m_cnt = (m_cnt <= 1) ? rl : m_cnt - 1;
            if (ctrl_wr) m_lfsr = 16384;
            else if (ex && m_phase == 0) begin
                m_out  = m_lfsr & 1;
                fb     = noise_ctrl[2] ? ((m_lfsr ^ (m_lfsr >> 1)) & 1) : (m_lfsr & 1);
                m_lfsr = (m_lfsr >> 1) | (fb << 14);
            end
            if (ex) m_phase ^= 1;
        end
    end

    always @(negedge clk) begin
        if (compare_on) begin
            check(cur_req, "noise_bit", noise_bit, m_out);
            check((atten == 4'hF) ? "R9" : "R8", "amp_sample", amp_sample,
                  m_out ? level(atten) : 0);
        end
    end

    // periodic stimulus generator
    always @(negedge clk) begin
        #1;
        gen_cnt++;
        ref_tick     <= (tick_div > 0) && (gen_cnt % tick_div == 0);
        tone2_expire <= (t2_div > 0) && (gen_cnt % t2_div == 0);
    end

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctrl(logic [2:0] v);
        @(negedge clk); #2;
        noise_ctrl = v; ctrl_wr = 1'b1;
        @(negedge clk); #2;
        ctrl_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int ones, rises;
        bit prev;
        wait_cycles(3);
        check("R1", "noise_bit after reset", noise_bit, 0);
        check("R1", "amp_sample after reset", amp_sample, 0);
        #2; rst = 1'b0; compare_on = 1'b1;

        // R2: three fixed rates, tick every cycle then sparse ticks
        cur_req = "R2"; tick_div = 1;
        wait_cycles(400);
        noise_ctrl = 3'b101; wait_cycles(500);
        write_ctrl(3'b110); tick_div = 3; wait_cycles(900);
        cur_req = "R4"; write_ctrl(3'b100); tick_div = 1; wait_cycles(300);

        // R3: tone 2 drives the noise, muted attenuation
        cur_req = "R3"; atten = 4'hF; tick_div = 2; t2_div = 5;
        write_ctrl(3'b111);
        rises = 0; prev = noise_bit;
        for (int i = 0; i < 600; i++) begin
            wait_cycles(1);
            if (noise_bit && !prev) rises++;
            prev = noise_bit;
        end
        checks++;
        if (rises == 0) begin
            fails++;
            $display("FAIL R3 noise activity with mute: actual %0d expected >0", rises);
        end
        atten = 4'd3; t2_div = 3; wait_cycles(300);

        // R6: periodic pulse count with tone 2 every cycle
        cur_req = "R6"; t2_div = 1; tick_div = 0; atten = 4'd0;
        write_ctrl(3'b011);
        rises = 0; prev = noise_bit;
        for (int i = 0; i < 305; i++) begin
            wait_cycles(1);
            if (noise_bit && !prev) rises++;
            prev = noise_bit;
        end
        check("R6", "ones in ~152 advances", rises, 10);

        // R7: reseed mid-stream, back to back
        cur_req = "R7";
        write_ctrl(3'b111); write_ctrl(3'b111); wait_cycles(60);

        // R5: full white period = 65534 cycles at one expiry per cycle
        cur_req = "R5"; write_ctrl(3'b111);
        wait_cycles(10);
        ones = 0;
        for (int i = 0; i < 65534; i++) begin
            wait_cycles(1);
            if (noise_bit) ones++;
        end
        check("R5", "one-cycles over a full period", ones, 32768);

        // R8: attenuation sweep on white noise at rate 0
        cur_req = "R8"; t2_div = 0; tick_div = 1;
        write_ctrl(3'b100);
        for (int k = 0; k < 16; k++) begin
            atten = 4'(k);
            wait_cycles(120);
        end

        compare_on = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule